// File: doc/BRIEF.md
# Store Set Dependence Predictor

This block decides, at load dispatch, whether a load may issue ahead of older stores whose addresses are not yet known or must wait for one particular store. It learns from ordering violations reported by the pipeline. Each violation binds the offending load and store to a shared set number. A second table, indexed by that set number, remembers the tag of the most recent in-flight store of the set whose address is still unknown. A load whose set has such a store is told to stall and is given that store's tag. Any other load is allowed to speculate.

Two lookups drive the block. A direct-mapped ID table is indexed by word-address bits of the instruction address. A last-store table is indexed by set number. The store pipeline writes the last-store table at dispatch and clears entries when an address resolves or when stores are squashed. A retirement counter empties both tables at a fixed interval. This drops old dependences so that a pair which conflicted long ago does not keep a load waiting for good.

Top module: `store_set_predictor`

## Requirements
- R1: After reset every ID-table and last-store entry is invalid, so a load query returns ld_stall=0.
- R2: A load query is combinational and reflects the table state as of the previous clock edge. ld_stall=1 exactly when ld_valid=1, the load's ID entry is valid, and the last-store entry of that ID is valid. ld_wait_tag then carries the recorded store tag.
- R3: Both tables are reached through an ID-table index equal to instruction-address bits [IDX_W+1:2]. Instructions whose addresses share these bits share an entry.
- R4: On a violation where neither the load's nor the store's entry is valid, both receive the value of an allocation counter. The counter starts at 0 after reset, wraps, and advances by one only on such an allocation.
- R5: On a violation where exactly one of the two entries is valid, both receive that existing ID and the allocation counter does not advance.
- R6: On a violation where both entries are valid, both are written with the smaller of the two IDs.
- R7: A dispatched store whose ID entry is valid writes its tag into the last-store entry of its set and marks it valid. A store with an invalid ID entry changes nothing.
- R8: An address resolution clears only those last-store entries whose recorded tag equals the resolving tag. A newer store recorded in the same set stays.
- R9: A flush clears every last-store entry whose recorded tag has its bit set in flush_mask (bit index = tag value).
- R10: When a dispatch write and a resolve or flush clear hit the same last-store entry in one cycle, the write takes effect.
- R11: retire_cnt is summed every cycle. On the edge where the sum reaches CLEAR_INTERVAL, the sum restarts at 0. At the following edge every valid bit of both tables drops, and any other update in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| viol_valid | input | 1 | Ordering violation report |
| viol_ld_pc | input | PC_W | Instruction address of the violating load |
| viol_st_pc | input | PC_W | Instruction address of the conflicting store |
| st_disp_valid | input | 1 | Store dispatch |
| st_disp_pc | input | PC_W | Instruction address of the dispatched store |
| st_disp_tag | input | TAG_W | In-flight tag of the dispatched store |
| st_res_valid | input | 1 | Store address resolved |
| st_res_tag | input | TAG_W | Tag of the resolving store |
| flush_valid | input | 1 | Squash of in-flight stores |
| flush_mask | input | 2**TAG_W | One bit per tag; set bits are squashed |
| retire_cnt | input | RET_W | Instructions retired this cycle |
| ld_valid | input | 1 | Load dispatch query |
| ld_pc | input | PC_W | Instruction address of the querying load |
| ld_stall | output | 1 | Load must wait |
| ld_wait_tag | output | TAG_W | Tag of the store to wait for |

## Verification
The embedded assertions check the following on every cycle: a violation leaves both instructions' entries valid and equal, a fresh allocation advances the counter by exactly one, a valid dispatch lands its tag in the addressed set, a matching resolve drops its entry, the periodic wipe empties both tables, and a stall is never raised without a valid ID. Other properties depend on sequences of events and are shown only by the bench's scenarios. These are: the smaller ID surviving a merge, reuse not consuming an allocation, a newer store surviving an older store's resolve, mask-selected flushing, write-over-clear priority within one cycle, address aliasing, and the exact edge at which the retirement count empties the tables.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef enum logic [1:0] {
    JOIN_NEW   = 2'd0,
    JOIN_LOAD  = 2'd1,
    JOIN_STORE = 2'd2,
    JOIN_MIN   = 2'd3
  } join_kind_e;

  // How a violation pair is folded into the ID table.
  function automatic join_kind_e join_kind(input logic ld_known, input logic st_known);
    if (ld_known && st_known) return JOIN_MIN;
    if (ld_known)             return JOIN_LOAD;
    if (st_known)             return JOIN_STORE;
    return JOIN_NEW;
  endfunction

endpackage

// File: rtl/ssp_clear_timer.sv
module ssp_clear_timer #(
  parameter int INTERVAL = 1 << 20,
  parameter int RET_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RET_W-1:0] retire_cnt,
  output logic             wipe
);
  localparam int CW = $clog2(INTERVAL + (1 << RET_W)) + 1;
  localparam logic [CW-1:0] LIMIT = CW'(INTERVAL);

  logic [CW-1:0] acc;
  logic [CW-1:0] acc_sum;
  logic          reach;

  assign acc_sum = acc + CW'(retire_cnt);
  assign reach   = (acc_sum >= LIMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      wipe <= 1'b0;
    end else begin
      wipe <= reach;
      acc  <= reach ? '0 : acc_sum;
    end
  end

  // R11
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc < LIMIT);

  // R11
  wipe_after_reach_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reach |=> wipe && (acc == '0));

endmodule

// File: rtl/ssp_id_table.sv
module ssp_id_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6,
  parameter int ID_W  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wipe,
  input  logic            viol_valid,
  input  logic [PC_W-1:0] viol_ld_pc,
  input  logic [PC_W-1:0] viol_st_pc,
  input  logic [PC_W-1:0] st_pc,
  input  logic [PC_W-1:0] ld_pc,
  output logic            st_id_valid,
  output logic [ID_W-1:0] st_id,
  output logic            ld_id_valid,
  output logic [ID_W-1:0] ld_id,
  output logic            alloc_fire
);
  import ssp_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;

  function automatic logic [ID_W-1:0] pick_id(input join_kind_e k,
                                              input logic [ID_W-1:0] fresh,
                                              input logic [ID_W-1:0] a,
                                              input logic [ID_W-1:0] b);
    case (k)
      JOIN_NEW:   return fresh;
      JOIN_LOAD:  return a;
      JOIN_STORE: return b;
      default:    return (a < b) ? a : b;
    endcase
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [ID_W-1:0]    ids [ENTRIES];
  logic [ID_W-1:0]    next_id;

  logic [IDX_W-1:0] v_li, v_si, s_i, l_i;
  join_kind_e       kind;
  logic [ID_W-1:0]  joined_id;
  logic             learn;

  logic unused_pc_bits;
  assign unused_pc_bits = ^{viol_ld_pc[PC_W-1:IDX_W+2], viol_ld_pc[1:0],
                            viol_st_pc[PC_W-1:IDX_W+2], viol_st_pc[1:0],
                            st_pc[PC_W-1:IDX_W+2], st_pc[1:0],
                            ld_pc[PC_W-1:IDX_W+2], ld_pc[1:0]};

  assign v_li = viol_ld_pc[IDX_W+1:2];
  assign v_si = viol_st_pc[IDX_W+1:2];
  assign s_i  = st_pc[IDX_W+1:2];
  assign l_i  = ld_pc[IDX_W+1:2];

  assign kind       = join_kind(vld[v_li], vld[v_si]);
  assign joined_id  = pick_id(kind, next_id, ids[v_li], ids[v_si]);
  assign learn      = viol_valid && !wipe;
  assign alloc_fire = learn && (kind == JOIN_NEW);

  assign st_id_valid = vld[s_i];
  assign st_id       = ids[s_i];
  assign ld_id_valid = vld[l_i];
  assign ld_id       = ids[l_i];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld     <= '0;
      next_id <= '0;
    end else if (wipe) begin
      vld <= '0;
    end else if (learn) begin
      vld[v_li] <= 1'b1;
      vld[v_si] <= 1'b1;
      if (alloc_fire) next_id <= next_id + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (learn) begin
      ids[v_li] <= joined_id;
      ids[v_si] <= joined_id;
    end
  end

  // R1 R11
  id_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (vld == '0));

  // R4
  id_alloc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> next_id == $past(next_id) + 1'b1);

  // R5 R6
  id_pair_joined_chk: assert property (@(posedge clk) disable iff (!rst_n)
    learn |=> vld[$past(v_li)] && vld[$past(v_si)] &&
              (ids[$past(v_li)] == ids[$past(v_si)]));

  // R4
  id_counter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alloc_fire |=> $stable(next_id));

endmodule

// File: rtl/ssp_last_store_table.sv
module ssp_last_store_table #(
  parameter int ID_W  = 6,
  parameter int TAG_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wipe,
  input  logic                wr_en,
  input  logic [ID_W-1:0]     wr_id,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic                res_valid,
  input  logic [TAG_W-1:0]    res_tag,
  input  logic                flush_valid,
  input  logic [(1<<TAG_W)-1:0] flush_mask,
  input  logic [ID_W-1:0]     rd_id,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag
);
  localparam int SETS = 1 << ID_W;

  logic [SETS-1:0]  busy;
  logic [TAG_W-1:0] tag [SETS];
  logic [SETS-1:0]  drop;
  logic [SETS-1:0]  put;

  for (genvar e = 0; e < SETS; e++) begin : g_ent
    assign put[e]  = wr_en && (wr_id == ID_W'(e));
    assign drop[e] = (res_valid && (tag[e] == res_tag)) ||
                     (flush_valid && flush_mask[tag[e]]);
  end

  assign rd_valid = busy[rd_id];
  assign rd_tag   = tag[rd_id];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= '0;
    end else if (wipe) begin
      busy <= '0;
    end else begin
      for (int e = 0; e < SETS; e++) begin
        if (put[e])       busy[e] <= 1'b1;
        else if (drop[e]) busy[e] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !wipe) tag[wr_id] <= wr_tag;
  end

  // R7 R10
  ls_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wipe) |=> busy[$past(wr_id)] && (tag[$past(wr_id)] == $past(wr_tag)));

  // R8
  ls_resolve_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && rd_valid && (rd_tag == res_tag) && !(wr_en && wr_id == rd_id))
      |=> !busy[$past(rd_id)]);

  // R1 R11
  ls_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (busy == '0));

endmodule

// File: rtl/store_set_predictor.sv
module store_set_predictor #(
  parameter int PC_W           = 32,
  parameter int IDX_W          = 6,
  parameter int ID_W           = 6,
  parameter int TAG_W          = 6,
  parameter int RET_W          = 3,
  parameter int CLEAR_INTERVAL = 1 << 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  viol_valid,
  input  logic [PC_W-1:0]       viol_ld_pc,
  input  logic [PC_W-1:0]       viol_st_pc,
  input  logic                  st_disp_valid,
  input  logic [PC_W-1:0]       st_disp_pc,
  input  logic [TAG_W-1:0]      st_disp_tag,
  input  logic                  st_res_valid,
  input  logic [TAG_W-1:0]      st_res_tag,
  input  logic                  flush_valid,
  input  logic [(1<<TAG_W)-1:0] flush_mask,
  input  logic [RET_W-1:0]      retire_cnt,
  input  logic                  ld_valid,
  input  logic [PC_W-1:0]       ld_pc,
  output logic                  ld_stall,
  output logic [TAG_W-1:0]      ld_wait_tag
);
  logic            wipe;
  logic            st_id_valid, ld_id_valid, alloc_fire;
  logic [ID_W-1:0] st_id, ld_id;
  logic            set_pending;
  logic            rec_store;

  ssp_clear_timer #(.INTERVAL(CLEAR_INTERVAL), .RET_W(RET_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .retire_cnt(retire_cnt), .wipe(wipe)
  );

  ssp_id_table #(.PC_W(PC_W), .IDX_W(IDX_W), .ID_W(ID_W)) u_ids (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .st_pc(st_disp_pc), .ld_pc(ld_pc),
    .st_id_valid(st_id_valid), .st_id(st_id),
    .ld_id_valid(ld_id_valid), .ld_id(ld_id),
    .alloc_fire(alloc_fire)
  );

  assign rec_store = st_disp_valid && st_id_valid;

  ssp_last_store_table #(.ID_W(ID_W), .TAG_W(TAG_W)) u_last (
    .clk(clk), .rst_n(rst_n), .wipe(wipe),
    .wr_en(rec_store), .wr_id(st_id), .wr_tag(st_disp_tag),
    .res_valid(st_res_valid), .res_tag(st_res_tag),
    .flush_valid(flush_valid), .flush_mask(flush_mask),
    .rd_id(ld_id), .rd_valid(set_pending), .rd_tag(ld_wait_tag)
  );

  assign ld_stall = ld_valid && ld_id_valid && set_pending;

  // R2
  stall_needs_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_stall |-> ld_valid && ld_id_valid);

  // R4
  alloc_only_on_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |-> viol_valid);

endmodule

// File: tb/store_set_predictor_bench.sv
module store_set_predictor_bench;
  localparam int PC_W = 32, TAG_W = 6, RET_W = 3, NT = 1 << TAG_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic viol_valid = 0, st_disp_valid = 0, st_res_valid = 0, flush_valid = 0, ld_valid = 0;
  logic [PC_W-1:0] viol_ld_pc = '0, viol_st_pc = '0, st_disp_pc = '0, ld_pc = '0;
  logic [TAG_W-1:0] st_disp_tag = '0, st_res_tag = '0;
  logic [NT-1:0] flush_mask = '0;
  logic [RET_W-1:0] retire_cnt = '0;
  logic ld_stall;
  logic [TAG_W-1:0] ld_wait_tag;

  always #2 clk = ~clk;

  store_set_predictor #(.CLEAR_INTERVAL(32)) u_store_set_predictor (
    .clk(clk), .rst_n(rst_n),
    .viol_valid(viol_valid), .viol_ld_pc(viol_ld_pc), .viol_st_pc(viol_st_pc),
    .st_disp_valid(st_disp_valid), .st_disp_pc(st_disp_pc), .st_disp_tag(st_disp_tag),
    .st_res_valid(st_res_valid), .st_res_tag(st_res_tag),
    .flush_valid(flush_valid), .flush_mask(flush_mask),
    .retire_cnt(retire_cnt), .ld_valid(ld_valid), .ld_pc(ld_pc),
    .ld_stall(ld_stall), .ld_wait_tag(ld_wait_tag)
  );

  // Index = address bits [7:2]
  localparam logic [PC_W-1:0] L1 = 32'h100, S1 = 32'h204, L2 = 32'h308, S2 = 32'h40C,
                              L3 = 32'h510, L4 = 32'h614, S4 = 32'h718, AL = 32'h1100;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit    q_stall[$];
  int    q_tag[$];
  string q_req[$];

  task automatic step_begin();
    @(posedge clk); #1;
    viol_valid = 0; st_disp_valid = 0; st_res_valid = 0; flush_valid = 0;
    ld_valid = 0; retire_cnt = '0; flush_mask = '0;
  endtask
  task automatic violate(input logic [PC_W-1:0] lp, input logic [PC_W-1:0] sp);
    step_begin(); viol_valid = 1; viol_ld_pc = lp; viol_st_pc = sp;
  endtask
  task automatic dispatch(input logic [PC_W-1:0] sp, input int tg);
    step_begin(); st_disp_valid = 1; st_disp_pc = sp; st_disp_tag = TAG_W'(tg);
  endtask
  task automatic resolve(input int tg);
    step_begin(); st_res_valid = 1; st_res_tag = TAG_W'(tg);
  endtask
  task automatic flush_tag(input int tg);
    step_begin(); flush_valid = 1; flush_mask[tg] = 1'b1;
  endtask
  task automatic retire(input int n);
    step_begin(); retire_cnt = RET_W'(n);
  endtask
  task automatic query(input logic [PC_W-1:0] lp, input bit stall, input int tg, input string req);
    step_begin(); ld_valid = 1; ld_pc = lp;
    q_stall.push_back(stall); q_tag.push_back(tg); q_req.push_back(req);
  endtask

  // Monitor: compare the combinational answer mid-cycle.
  always @(negedge clk) begin
    if (ld_valid && q_stall.size() > 0) begin
      bit es; int et; string rq;
      es = q_stall.pop_front(); et = q_tag.pop_front(); rq = q_req.pop_front();
      checks++;
      if (ld_stall !== es || (es && ld_wait_tag !== TAG_W'(et))) begin
        errors++;
        $display("FAIL %s: stall=%0b tag=%0d expected stall=%0b tag=%0d",
                 rq, ld_stall, ld_wait_tag, es, et);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run incomplete, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    query(L1, 0, 0, "R1 reset empty");
    dispatch(S1, 5);
    violate(L1, S1);                       // new set 0
    query(L1, 0, 0, "R7 unlearned dispatch ignored");
    dispatch(S1, 7);
    query(L1, 1, 7, "R2 stall on pending store");
    query(AL, 1, 7, "R3 aliased address shares entry");
    resolve(3);
    query(L1, 1, 7, "R8 other tag keeps entry");
    resolve(7);
    query(L1, 0, 0, "R8 matching tag clears");
    violate(L2, S2);                       // new set 1
    violate(L2, S1);                       // merge 1,0 -> 0
    dispatch(S1, 9);
    query(L2, 1, 9, "R6 merged into smaller id");
    resolve(9);
    dispatch(S2, 4);
    query(L2, 0, 0, "R6 load left old set");
    resolve(4);
    violate(L3, S1);                       // reuse set 0
    violate(L4, S4);                       // new set 2
    dispatch(S4, 11);
    query(L4, 1, 11, "R4 fresh id distinct");
    query(L3, 0, 0, "R5 reused set idle");
    dispatch(S1, 12);
    query(L3, 1, 12, "R5 reused store id");
    resolve(11);
    dispatch(S1, 13);
    resolve(12);
    query(L1, 1, 13, "R8 newer store survives");
    resolve(13);
    dispatch(S4, 20);
    flush_tag(20);
    query(L4, 0, 0, "R9 flushed tag cleared");
    dispatch(S4, 21);
    flush_tag(22);
    query(L4, 1, 21, "R9 unflushed tag kept");
    resolve(21);
    dispatch(S1, 30);
    step_begin(); st_disp_valid = 1; st_disp_pc = S1; st_disp_tag = 31;
    st_res_valid = 1; st_res_tag = 30;
    query(L1, 1, 31, "R10 write beats resolve");
    step_begin(); st_disp_valid = 1; st_disp_pc = S1; st_disp_tag = 33;
    flush_valid = 1; flush_mask[31] = 1'b1;
    query(L1, 1, 33, "R10 write beats flush");
    resolve(33);
    dispatch(S1, 40);
    for (int i = 0; i < 4; i++) retire(7);
    retire(3);
    query(L1, 1, 40, "R11 below interval");
    retire(1);
    query(L1, 1, 40, "R11 wipe not yet applied");
    query(L1, 0, 0, "R11 tables wiped");
    query(L2, 0, 0, "R11 merged entry wiped");
    dispatch(S1, 41);
    violate(L1, S1);                       // counter now 3
    dispatch(S1, 42);
    query(L1, 1, 42, "R4 relearn after wipe");
    step_begin();
    step_begin();
    if (q_stall.size() != 0) begin
      errors++; checks++;
      $display("FAIL R2: %0d queries unanswered, expected 0", q_stall.size());
    end
    finish_run();
  end
endmodule